// File: doc/BRIEF.md
# Vector Fixed-Point Multiply Unit

This unit runs one multiply-group instruction at a time over a run of consecutive registers in a 128-entry, 32-bit register file. The register file sits outside the unit. The unit drives two combinational read addresses, receives the data in the same cycle, and emits at most one register write per cycle. The contents of register 1 arrive on a dedicated scale input.

An instruction chooses three things:
- the product shape: 16×16 or 32×16, with an arithmetic right shift of 0, 8 or 16 bits;
- the operation: element-wise multiply, dot product, or A·scale + B;
- whether to round before the shift.

After the instruction is accepted, the unit walks N elements, one per cycle. It holds busy high for those N cycles and refuses new work until it finishes.

Instruction layout:

| Bits | Field |
|------|-------|
| 31:28 | product form |
| 27:24 | element count minus one |
| 23 | round |
| 22:21 | operation |
| 20:14 | source A base |
| 13:7 | destination base |
| 6:0 | source B base |

Register indices wrap modulo 128.

Top module: `vec_fxmul`

## Requirements
- R1: After reset, `instr_ready` is 1, `busy` is 0 and `wr_en` is 0.
- R2: An element-wise multiply (operation 0) with count field C writes N = C+1 results. Element i goes to register d+i and uses A register a+i and B register b+i. Every index is taken modulo 128.
- R3: Form codes 0, 1 and 2 multiply the signed low 16 bits of A by the signed low 16 bits of the multiplier. Form codes 4, 5 and 6 multiply all 32 bits of A, taken as signed, by the signed low 16 bits of the multiplier.
- R4: Bits 29:28 of the form give the arithmetic right shift: 0 shifts by 0, 1 by 8, 2 by 16. The low 32 bits of the shifted value are the result.
- R5: When bit 23 is set and the shift is nonzero, 1 << (shift−1) is added to the full-precision value before shifting. With a shift of 0, bit 23 changes nothing.
- R6: A dot product (operation 1) sums all N full-precision products. It rounds and shifts the sum once, and writes only to register d, in the last element's cycle.
- R7: Scale-and-add (operation 2) multiplies A by the signed low 16 bits of the scale input (register 1). It shifts and rounds that product as in R4 and R5, then adds all 32 bits of B modulo 2^32.
- R8: An operand read from register 0 is taken as zero, whatever data the port returns.
- R9: A write aimed at register 0 is dropped. The other elements of the same instruction are still written.
- R10: `busy` rises in the cycle after acceptance and stays high for exactly N cycles. Each element's write is presented during its own busy cycle. `instr_ready` is low while busy, and no write appears while idle.
- R11: Some instructions are unsupported: form codes 3 and 7, form codes 8 to 15, and operation 3. They are accepted and have no effect: no write, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr | input | 32 | Multiply-group instruction word |
| busy | output | 1 | An instruction is being executed |
| rd_a_addr | output | 7 | Read address, source A element |
| rd_a_data | input | 32 | Register contents at rd_a_addr |
| rd_b_addr | output | 7 | Read address, source B element |
| rd_b_data | input | 32 | Register contents at rd_b_addr |
| scale_in | input | 32 | Contents of register 1 |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 7 | Register write address |
| wr_data | output | 32 | Register write data |

## Verification
The hardest behaviour to reach from the ports is the interplay between index wrap-around and the register-0 rules inside one instruction. A run must cross from index 127 to 0, so that one element reads a zero operand while the port returns junk, and another element's write is dropped while its neighbours land. The stimulus loads register 0 of the bench's register file with a nonzero pattern. It then issues runs whose bases sit near the top of the index space, and a run whose destination base is 0. A 16-element dot product in the widest form with rounding exercises the accumulator at its full width.

// File: rtl/vec_fxmul.sv
module vec_fxmul #(
  parameter int DW = 32,
  parameter int RW = 7,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [31:0]   instr,
  output logic          busy,
  output logic [RW-1:0] rd_a_addr,
  input  logic [DW-1:0] rd_a_data,
  output logic [RW-1:0] rd_b_addr,
  input  logic [DW-1:0] rd_b_data,
  input  logic [DW-1:0] scale_in,
  output logic          wr_en,
  output logic [RW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;
  localparam logic [1:0] OP_DOT = 2'd1;
  localparam logic [1:0] OP_SAX = 2'd2;

  logic [1:0]    sh_q, op_q;
  logic          wide_q, rnd_q;
  logic [RW-1:0] ra_q, rd_q, rb_q;
  logic [CW-1:0] idx_q, last_q;
  logic signed [AW-1:0] acc_q;

  logic [3:0] f_in;
  logic       legal;
  assign f_in  = instr[31:28];
  assign legal = !f_in[3] && (f_in[1:0] != 2'd3) && (instr[22:21] != 2'd3);

  assign instr_ready = !busy;
  wire accept = instr_valid && instr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      sh_q   <= '0;
      op_q   <= '0;
      wide_q <= 1'b0;
      rnd_q  <= 1'b0;
      ra_q   <= '0;
      rd_q   <= '0;
      rb_q   <= '0;
      acc_q  <= '0;
    end else if (accept) begin
      busy   <= legal;
      idx_q  <= '0;
      last_q <= instr[24 +: CW];
      sh_q   <= f_in[1:0];
      wide_q <= f_in[2];
      rnd_q  <= instr[23];
      op_q   <= instr[22:21];
      ra_q   <= instr[14 +: RW];
      rd_q   <= instr[7 +: RW];
      rb_q   <= instr[0 +: RW];
      acc_q  <= '0;
    end else if (busy) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == last_q) busy <= 1'b0;
      if (op_q == OP_DOT) acc_q <= sum;
    end
  end

  wire [RW-1:0] idx_ext = {{(RW-CW){1'b0}}, idx_q};
  assign rd_a_addr = ra_q + idx_ext;
  assign rd_b_addr = rb_q + idx_ext;

  wire [DW-1:0] a_val = (rd_a_addr == '0) ? '0 : rd_a_data;
  wire [DW-1:0] b_val = (rd_b_addr == '0) ? '0 : rd_b_data;
  wire [HW-1:0] m_val = (op_q == OP_SAX) ? scale_in[HW-1:0] : b_val[HW-1:0];

  logic signed [AW-1:0] a_ext, m_ext, prod, sum, rconst, rounded, shifted;
  logic [4:0] sh_amt;

  always_comb begin
    a_ext   = wide_q ? AW'($signed(a_val)) : AW'($signed(a_val[HW-1:0]));
    m_ext   = AW'($signed(m_val));
    prod    = a_ext * m_ext;
    sum     = (op_q == OP_DOT) ? acc_q + prod : prod;
    sh_amt  = {sh_q, 3'b000};
    rconst  = (rnd_q && sh_q != 2'd0) ? (AW'(1) <<< (sh_amt - 5'd1)) : '0;
    rounded = sum + rconst;
    shifted = rounded >>> sh_amt;
  end

  wire last_el = (idx_q == last_q);
  assign wr_addr = rd_q + ((op_q == OP_DOT) ? '0 : idx_ext);
  assign wr_data = shifted[DW-1:0] + ((op_q == OP_SAX) ? b_val : '0);
  assign wr_en   = busy && ((op_q != OP_DOT) || last_el) && (wr_addr != '0);
endmodule

// File: rtl/vec_fxmul_chk.sv
module vec_fxmul_chk #(
  parameter int RW = 7,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [31:0]   instr,
  input logic          busy,
  input logic          wr_en,
  input logic [RW-1:0] wr_addr
);
  logic [CW:0] cyc_cnt, exp_n, wr_cnt;
  logic        dot_q;
  wire acc_ok = instr_valid && instr_ready;
  wire ok_code = !instr[31] && (instr[29:28] != 2'd3) && (instr[22:21] != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      exp_n   <= '0;
      wr_cnt  <= '0;
      dot_q   <= 1'b0;
    end else if (acc_ok) begin
      cyc_cnt <= '0;
      wr_cnt  <= '0;
      exp_n   <= {1'b0, instr[24 +: CW]} + 1'b1;
      dot_q   <= (instr[22:21] == 2'd1);
    end else begin
      if (busy) cyc_cnt <= cyc_cnt + 1'b1;
      if (wr_en) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc_cnt == exp_n);
  // R10
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !instr_ready);
  // R9
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr != '0);
  // R11
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !ok_code) |=> !busy);
  // R6
  dot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && dot_q) |-> wr_cnt <= 1);
endmodule

bind vec_fxmul vec_fxmul_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr(instr), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/vec_fxmul_tb.sv
module vec_fxmul_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic instr_ready, busy, wr_en;
  logic [6:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic [31:0] rf [128];
  logic [31:0] shadow [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_a_data = rf[rd_a_addr];
  assign rd_b_data = rf[rd_b_addr];
  always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

  vec_fxmul u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .busy(busy), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .scale_in(rf[1]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, errors = 0, writes_seen = 0;
  logic [6:0]  q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  function automatic logic [31:0] enc(int form, bit rnd, int op, int n, int a, int d, int b);
    logic [31:0] w;
    w = {form[3:0], 4'(n - 1), rnd, op[1:0], a[6:0], d[6:0], b[6:0]};
    return w;
  endfunction

  function automatic logic [31:0] rdv(int idx);
    return (idx % 128 == 0) ? 32'd0 : shadow[idx % 128];
  endfunction

  function automatic longint mulx(bit wide, logic [31:0] av, logic [31:0] mv);
    longint x, y;
    x = wide ? longint'($signed(av)) : longint'($signed(av[15:0]));
    y = longint'($signed(mv[15:0]));
    return x * y;
  endfunction

  function automatic logic [31:0] fin(longint v, int sh, bit rnd);
    longint t;
    t = v;
    if (rnd && sh > 0) t = t + (longint'(1) << (sh - 1));
    t = t >>> sh;
    return t[31:0];
  endfunction

  task automatic push(int addr, logic [31:0] val, string tag);
    if (addr % 128 != 0) begin
      q_addr.push_back(7'(addr % 128));
      q_data.push_back(val);
      q_tag.push_back(tag);
      shadow[addr % 128] = val;
    end
  endtask

  task automatic issue(logic [31:0] w, string tag);
    int form, op, n, sh, nb;
    bit rnd, wide, ok;
    longint accum;
    logic [31:0] r;
    form = int'(w[31:28]); op = int'(w[22:21]); n = int'(w[27:24]) + 1;
    rnd = w[23]; wide = w[30]; sh = 8 * int'(w[29:28]);
    ok = (form < 8) && (form % 4 != 3) && (op != 3);
    accum = 0;
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        int ia, ib;
        ia = int'(w[20:14]) + i; ib = int'(w[6:0]) + i;
        if (op == 0) begin
          push(int'(w[13:7]) + i, fin(mulx(wide, rdv(ia), rdv(ib)), sh, rnd), tag);
        end else if (op == 2) begin
          r = fin(mulx(wide, rdv(ia), shadow[1]), sh, rnd) + rdv(ib);
          push(int'(w[13:7]) + i, r, tag);
        end else begin
          accum = accum + mulx(wide, rdv(ia), rdv(ib));
        end
      end
      if (op == 1) push(int'(w[13:7]), fin(accum, sh, rnd), tag);
    end
    @(posedge clk); #1;
    instr = w; instr_valid = 1'b1;
    while (!instr_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    instr_valid = 1'b0;
    nb = 0;
    forever begin
      @(negedge clk);
      if (busy) nb++; else break;
    end
    checks++;
    if (nb != (ok ? n : 0)) begin
      errors++;
      $display("FAIL R10 %s busy cycles actual=%0d expected=%0d", tag, nb, ok ? n : 0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      writes_seen++;
      checks++;
      if (!busy) begin
        errors++;
        $display("FAIL R10 write while idle actual busy=0 expected busy=1");
      end
      if (q_addr.size() == 0) begin
        errors++;
        $display("FAIL R9 R11 unexpected write actual addr=%0d data=%h expected none", wr_addr, wr_data);
      end else begin
        logic [6:0] ea; logic [31:0] ed; string et;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
        if (wr_addr !== ea || wr_data !== ed) begin
          errors++;
          $display("FAIL %s actual addr=%0d data=%h expected addr=%0d data=%h", et, wr_addr, wr_data, ea, ed);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int ws;
    for (int i = 0; i < 128; i++) begin
      rf[i] = $urandom();
      shadow[i] = rf[i];
    end
    rf[0] = 32'hA5C3_0F11;
    rf[1] = 32'hFFFF_FE40; shadow[1] = rf[1];
    rf[21] = 32'h0000_8000; shadow[21] = rf[21];
    rf[11] = 32'h7FFF_FFFF; shadow[11] = rf[11];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (instr_ready !== 1'b1 || busy !== 1'b0 || wr_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 actual ready=%b busy=%b wr=%b expected 1 0 0", instr_ready, busy, wr_en);
    end

    issue(enc(0, 0, 0, 4, 10, 40, 20), "R2 R3 mul16 sh0");
    issue(enc(1, 1, 0, 3, 12, 44, 22), "R4 R5 mul16 sh8 round");
    issue(enc(1, 0, 0, 3, 12, 48, 22), "R4 mul16 sh8");
    issue(enc(2, 1, 0, 4, 14, 52, 24), "R4 R5 mul16 sh16 round");
    issue(enc(4, 0, 0, 2, 10, 56, 20), "R3 mul32x16 sh0");
    issue(enc(5, 1, 0, 3, 10, 58, 20), "R3 R5 mul32x16 sh8 round");
    issue(enc(6, 1, 0, 3, 11, 62, 21), "R3 R4 mul32x16 sh16 round");
    issue(enc(0, 1, 0, 2, 10, 66, 20), "R5 round with sh0");
    issue(enc(0, 0, 1, 5, 30, 70, 35), "R6 dot16");
    issue(enc(6, 1, 1, 16, 80, 71, 96), "R6 dot32x16 sh16 round");
    issue(enc(1, 1, 2, 4, 10, 100, 20), "R7 saxp sh8 round");
    issue(enc(4, 0, 2, 2, 11, 104, 21), "R7 saxp 32x16");
    issue(enc(0, 0, 0, 3, 0, 110, 20), "R8 zero source");
    issue(enc(0, 0, 0, 4, 126, 126, 124), "R2 R8 R9 wrap");

    ws = writes_seen;
    issue(enc(3, 0, 0, 2, 10, 112, 20), "R11 form3");
    issue(enc(7, 0, 0, 2, 10, 112, 20), "R11 form7");
    issue(enc(9, 0, 0, 2, 10, 112, 20), "R11 form9");
    issue(enc(0, 0, 3, 2, 10, 112, 20), "R11 op3");
    checks++;
    if (writes_seen != ws) begin
      errors++;
      $display("FAIL R11 writes actual=%0d expected=%0d", writes_seen - ws, 0);
    end

    issue(enc(0, 0, 0, 3, 10, 0, 20), "R9 dest zero");
    issue(enc(2, 1, 2, 2, 12, 114, 22), "R7 saxp after scale change");

    repeat (3) @(negedge clk);
    checks++;
    if (q_addr.size() != 0) begin
      errors++;
      $display("FAIL R2 pending writes actual=%0d expected=0", q_addr.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule